// File: doc/BRIEF.md
# Wide Word to Byte Stream Serializer

This block sits between a memory read path and a byte-wide serial transmitter. A central controller hands it one wide word (128 bits by default) under a request/acknowledge handshake. The block captures the word and passes it to the transmitter one byte at a time. Before it offers the next byte, it waits for the transmitter to report that the current byte has gone out.

Each byte is offered with a one-cycle start strobe. The block then waits, with start held low, until the transmitter's done pulse arrives. Next it decides whether bytes remain. When the last byte has been reported done, the block stays parked and waits for the controller to withdraw its request. Only then does it return to idle and accept another word. A request held high therefore never starts the same word twice.

Top module: `word_byte_serializer`

## Requirements
- R1: After reset the block is idle. `ack_o` and `start_o` are low and stay low until a request is seen.
- R2: When `req_i` is high while the block is idle, `ack_o` is high in the next cycle for exactly one cycle. `word_i` is captured at that same clock edge, and later changes on `word_i` do not alter the bytes sent for that request.
- R3: `start_o` is high for exactly one cycle per byte, and `byte_o` carries that byte in the same cycle. The first byte's strobe coincides with the `ack_o` pulse.
- R4: After a start strobe, `start_o` stays low until `tx_done_i` has been seen high. The next strobe comes two cycles after the cycle in which `tx_done_i` is high.
- R5: Bytes go out in ascending lane order: bits 7:0 first, then bits 15:8, and so on up to bits 127:120.
- R6: Each accepted request produces exactly sixteen start strobes. This holds even if `req_i` falls before the transfer ends.
- R7: After the sixteenth byte is reported done, no `ack_o` and no `start_o` occur while `req_i` stays high. The block returns to idle in the first cycle `req_i` is low, and accepts a new request after that.
- R8: A `tx_done_i` pulse while the block is idle has no effect. No strobe and no acknowledge follow it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Controller request to send a word |
| ack_o | output | 1 | One-cycle acknowledge of an accepted request |
| word_i | input | WORD_W | Word to serialize, captured on acceptance |
| byte_o | output | BYTE_W | Byte currently offered to the transmitter |
| start_o | output | 1 | One-cycle strobe telling the transmitter to send `byte_o` |
| tx_done_i | input | 1 | Transmitter pulse: the current byte has been sent |

## Verification
The assertions check on every cycle that the acknowledge and start strobes are single-cycle pulses and that an acknowledge always comes with the first strobe and follows a request. They also check that no strobe appears while a byte is still outstanding, that no request gets more than sixteen strobes, and that a new acknowledge comes only after a full transfer. Byte values and their lane order, capture of the word at acceptance, parking while the request stays high, and the harmlessness of a stray done pulse in idle depend on data and sequencing. Only the bench's scenarios show these: a transmitter model with random done latency, several words sent back to back, and a request dropped early.

// File: rtl/wbs_pkg.sv
package wbs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SEND  = 3'd1,
        ST_WAIT  = 3'd2,
        ST_CHECK = 3'd3,
        ST_PARK  = 3'd4
    } wbs_state_e;

endpackage

// File: rtl/wbs_lane_counter.sv
module wbs_lane_counter #(
    parameter int NUM_LANES = 16,
    localparam int IDX_W    = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             last_o
);

    logic [IDX_W-1:0] idx_d, idx_q;

    always_comb begin
        idx_d = idx_q;
        if (clr_i) begin
            idx_d = '0;
        end else if (inc_i) begin
            idx_d = idx_q + IDX_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else begin
            idx_q <= idx_d;
        end
    end

    assign idx_o  = idx_q;
    assign last_o = (idx_q == IDX_W'(NUM_LANES - 1));

endmodule

// File: rtl/wbs_lane_select.sv
module wbs_lane_select #(
    parameter int WORD_W = 128,
    parameter int BYTE_W = 8,
    localparam int NUM_LANES = WORD_W / BYTE_W,
    localparam int IDX_W     = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1,
    localparam int SLOTS     = 1 << IDX_W
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [BYTE_W-1:0] byte_o
);

    logic [BYTE_W-1:0] lanes [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_lane
        if (g < NUM_LANES) begin : g_used
            assign lanes[g] = word_i[g*BYTE_W +: BYTE_W];
        end else begin : g_pad
            assign lanes[g] = '0;
        end
    end

    assign byte_o = lanes[idx_i];

endmodule

// File: rtl/word_byte_serializer.sv
module word_byte_serializer #(
    parameter int WORD_W = 128,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    output logic              ack_o,
    input  logic [WORD_W-1:0] word_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic              start_o,
    input  logic              tx_done_i
);
    import wbs_pkg::*;

    localparam int NUM_BYTES = WORD_W / BYTE_W;
    localparam int IDX_W     = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;

    typedef struct packed {
        wbs_state_e        state;
        logic [WORD_W-1:0] word;
        logic              ack;
    } ser_regs_t;

    ser_regs_t        regs_d, regs_q;
    logic             cnt_clr, cnt_inc, cnt_last;
    logic [IDX_W-1:0] cnt_idx;

    always_comb begin
        regs_d     = regs_q;
        regs_d.ack = 1'b0;
        cnt_clr    = 1'b0;
        cnt_inc    = 1'b0;
        unique case (regs_q.state)
            ST_IDLE: begin
                if (req_i) begin
                    regs_d.word  = word_i;
                    regs_d.ack   = 1'b1;
                    regs_d.state = ST_SEND;
                    cnt_clr      = 1'b1;
                end
            end
            ST_SEND: begin
                regs_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (tx_done_i) begin
                    regs_d.state = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (cnt_last) begin
                    regs_d.state = ST_PARK;
                end else begin
                    cnt_inc      = 1'b1;
                    regs_d.state = ST_SEND;
                end
            end
            ST_PARK: begin
                if (!req_i) begin
                    regs_d.state = ST_IDLE;
                end
            end
            default: begin
                regs_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.state <= ST_IDLE;
            regs_q.word  <= '0;
            regs_q.ack   <= 1'b0;
        end else begin
            regs_q <= regs_d;
        end
    end

    wbs_lane_counter #(
        .NUM_LANES (NUM_BYTES)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (cnt_clr),
        .inc_i  (cnt_inc),
        .idx_o  (cnt_idx),
        .last_o (cnt_last)
    );

    wbs_lane_select #(
        .WORD_W (WORD_W),
        .BYTE_W (BYTE_W)
    ) u_sel (
        .word_i (regs_q.word),
        .idx_i  (cnt_idx),
        .byte_o (byte_o)
    );

    assign ack_o   = regs_q.ack;
    assign start_o = (regs_q.state == ST_SEND);

endmodule

// File: rtl/wbs_checker.sv
module wbs_checker #(
    parameter int NUM_BYTES = 16,
    localparam int CNT_W    = $clog2(NUM_BYTES + 1)
) (
    input logic clk,
    input logic rst_n,
    input logic req_i,
    input logic ack_o,
    input logic start_o,
    input logic tx_done_i
);

    logic             pend_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            if (start_o) begin
                pend_q <= 1'b1;
            end else if (tx_done_i) begin
                pend_q <= 1'b0;
            end
            if (ack_o) begin
                cnt_q <= CNT_W'(1);
            end else if (start_o) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    a_r2_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);

    a_r2_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> $past(req_i));

    a_r3_ack_with_start: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> start_o);

    a_r3_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);

    a_r4_wait_done: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> !pend_q);

    a_r6_max_bytes: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o && !ack_o) |-> (cnt_q < CNT_W'(NUM_BYTES)));

    a_r7_ack_after_full: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> (cnt_q == '0 || cnt_q == CNT_W'(NUM_BYTES)));

endmodule

bind word_byte_serializer wbs_checker #(
    .NUM_BYTES (NUM_BYTES)
) u_wbs_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .ack_o     (ack_o),
    .start_o   (start_o),
    .tx_done_i (tx_done_i)
);

// File: tb/tb_word_byte_serializer.sv
module tb_word_byte_serializer;

    localparam int CLK_PERIOD = 10;
    localparam int WORD_W     = 128;
    localparam int BYTE_W     = 8;
    localparam int NBYTES     = WORD_W / BYTE_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req = 1'b0;
    logic              ack;
    logic [WORD_W-1:0] word = '0;
    logic [BYTE_W-1:0] byt;
    logic              start;
    logic              done_mon = 1'b0;
    logic              done_stray = 1'b0;
    logic              done;

    assign done = done_mon | done_stray;

    int checks = 0;
    int fails = 0;
    int bytes_done = 0;
    logic [BYTE_W-1:0] exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    word_byte_serializer #(
        .WORD_W (WORD_W),
        .BYTE_W (BYTE_W)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req),
        .ack_o     (ack),
        .word_i    (word),
        .byte_o    (byt),
        .start_o   (start),
        .tx_done_i (done)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: transmitter model and scoreboard compare (R3, R4, R5, R6)
    initial begin
        logic [BYTE_W-1:0] e;
        int lat;
        wait (rst_n);
        forever begin
            @(negedge clk);
            if (start) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 strobe with no byte expected", WORD_W'(byt), '0);
                end else begin
                    e = exp_q.pop_front();
                    chk(byt == e, "R5 byte order", WORD_W'(byt), WORD_W'(e));
                end
                lat = $urandom_range(1, 6);
                for (int i = 0; i < lat; i++) begin
                    @(negedge clk);
                    chk(start == 1'b0, "R4 start low until done", WORD_W'(start), '0);
                end
                done_mon = 1'b1;
                @(negedge clk);
                done_mon = 1'b0;
                bytes_done++;
            end
        end
    end

    task automatic send_word(input logic [WORD_W-1:0] w, input bit keep_req);
        int target;
        @(negedge clk);
        for (int k = 0; k < NBYTES; k++) exp_q.push_back(w[k*BYTE_W +: BYTE_W]);
        target = bytes_done + NBYTES;
        req  = 1'b1;
        word = w;
        @(negedge clk);
        chk(ack == 1'b1, "R2 ack after request", WORD_W'(ack), 1);
        chk(start == 1'b1, "R3 first strobe with ack", WORD_W'(start), 1);
        word = ~w;
        if (!keep_req) req = 1'b0;
        @(negedge clk);
        chk(ack == 1'b0, "R2 ack single cycle", WORD_W'(ack), 0);
        wait (bytes_done == target);
        chk(exp_q.size() == 0, "R6 sixteen bytes sent", WORD_W'(exp_q.size()), 0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(start == 1'b0 && ack == 1'b0, "R7 parked while request high",
                WORD_W'({ack, start}), 0);
        end
        req = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(ack == 1'b0 && start == 1'b0, "R1 outputs low in reset", WORD_W'({ack, start}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(ack == 1'b0 && start == 1'b0, "R1 idle after reset", WORD_W'({ack, start}), 0);

        // R8: stray done in idle
        done_stray = 1'b1;
        @(negedge clk);
        done_stray = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(ack == 1'b0 && start == 1'b0, "R8 stray done ignored", WORD_W'({ack, start}), 0);
        end

        send_word(128'h0F0E0D0C0B0A09080706050403020100, 1'b1);
        send_word(128'hDEADBEEF_CAFEF00D_12345678_9ABCDEF0, 1'b1);
        send_word(128'hFF00FF00_00FF00FF_A5A5A5A5_5A5A5A5A, 1'b0);
        send_word({$urandom, $urandom, $urandom, $urandom}, 1'b1);
        send_word({$urandom, $urandom, $urandom, $urandom}, 1'b0);

        // R7: after request drops, block is idle and a stray done does nothing
        @(negedge clk);
        done_stray = 1'b1;
        @(negedge clk);
        done_stray = 1'b0;
        repeat (2) @(negedge clk);
        chk(ack == 1'b0 && start == 1'b0, "R7 idle after request low", WORD_W'({ack, start}), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule